// File: doc/BRIEF.md
# Oversampling Serial Receiver with Overrun-Gated Data Transfer

This block receives asynchronous serial characters. It samples a serial input line on a tick that runs at sixteen times the bit rate. A low level seen in idle is treated as the leading edge of a start bit. If the line is still low at the middle of that start bit, the frame is confirmed. The receiver then takes each data bit at its centre, least significant bit first. An optional parity bit follows the data, and then one stop bit.

When the stop bit has been sampled, the receiver decides whether the assembled character goes into the holding data register. A character that is still unread blocks the new one and raises the overrun flag. A bad stop bit or a parity mismatch is flagged, but the character is still delivered. Every error flag is sticky and is cleared only by its own strobe. Because of this, a held-low line (a break) sets the framing flag again on every frame it produces, even after software has cleared it.

The synchronised line level is also brought out directly. Software can read it to tell a break from an ordinary framing error.

Top module: `uart_rx_gate`

## Requirements
- R1: In idle, a 0 seen on the synchronised line at a tick starts a frame. The line is sampled again 8 ticks later. If it reads 1 there, the receiver returns to idle and nothing is reported. If it reads 0, the start bit is confirmed.
- R2: After a confirmed start, the receiver samples 8 data bits, one every 16 ticks, and assembles them least significant bit first. When parity is enabled, the parity bit follows the data and is sampled 16 ticks after the last data bit. The stop bit is sampled 16 ticks after that.
- R3: When a character completes and the full flag is clear, the character is written to `rdata_o` and `full_o` is set. A pulse on `rd_data_i` clears `full_o`.
- R4: When a character completes and `full_o` is still set, `ovr_o` is set and `rdata_o` keeps its old value.
- R5: A stop bit sampled as 0 sets `frm_err_o`, and the character is still written to `rdata_o`.
- R6: When parity is enabled, `par_err_o` is set if the received parity bit does not match the data. The expected parity bit is the XOR of the data bits when `par_odd_i`=0 (even parity), and the inverse of that XOR when `par_odd_i`=1 (odd parity). The character is still written to `rdata_o`.
- R7: An overrun together with a framing error and/or a parity error sets every applicable flag and leaves `rdata_o` unchanged.
- R8: The flags `ovr_o`, `frm_err_o` and `par_err_o` each clear only through their own strobe (`clr_ovr_i`, `clr_frm_i`, `clr_par_i`). While the line is held at 0 (a break), frames keep completing, so `frm_err_o` sets again after it has been cleared.
- R9: While `rx_en_i` is 0, the receiver stays idle and completes no character. Dropping `rx_en_i` clears none of the flags.
- R10: `line_o` shows the level of `rxd_i` after a two-flop synchroniser. It follows the line two clocks later.
- R11: After reset, `rdata_o` is 0, all four flags are 0, and `line_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial input line |
| tick16_i | input | 1 | One-clock pulse at 16x the bit rate |
| par_en_i | input | 1 | 1 = a parity bit follows the data |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rx_en_i | input | 1 | Receiver enable |
| rd_data_i | input | 1 | Read strobe for the data register; clears the full flag |
| clr_ovr_i | input | 1 | Clears the overrun flag |
| clr_frm_i | input | 1 | Clears the framing error flag |
| clr_par_i | input | 1 | Clears the parity error flag |
| rdata_o | output | 8 | Received data register |
| full_o | output | 1 | Data register holds an unread character |
| ovr_o | output | 1 | Sticky overrun flag |
| frm_err_o | output | 1 | Sticky framing error flag |
| par_err_o | output | 1 | Sticky parity error flag |
| line_o | output | 1 | Synchronised line level |

## Verification
The hardest case to reach from the ports is R7. An overrun must coincide with both a bad stop bit and a parity mismatch, while the earlier character is still unread. The bench gets there in three steps: it leaves one good character in the data register without reading it, then sends a second character with its parity bit inverted and its stop bit forced low, and then checks that all three flags are set while `rdata_o` still holds the first character. The re-setting of the framing flag during a break is reached by holding the line low across several frame lengths and pulsing the clear strobe between two frame completions.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  // Parity bit a correct sender places after the data.
  function automatic logic exp_par_bit(input logic [7:0] data, input logic odd);
    return (^data) ^ odd;
  endfunction

  // 1 when the received parity bit disagrees with the data.
  function automatic logic par_mismatch(input logic [7:0] data, input logic pbit,
                                        input logic odd);
    return pbit != exp_par_bit(data, odd);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              en,
  input  logic              par_en,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_o,
  output logic              pbit_o,
  output logic              par_used_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             at_mid;
  logic             at_full;

  assign at_mid  = tick && (cnt == MID_CNT);
  assign at_full = tick && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      idx        <= '0;
      data_o     <= '0;
      stop_o     <= 1'b1;
      pbit_o     <= 1'b0;
      par_used_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        unique case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (!line) state <= ST_START;
          end
          ST_START: begin
            if (at_mid) begin
              cnt   <= '0;
              idx   <= '0;
              state <= line ? ST_IDLE : ST_DATA;
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (at_full) begin
              cnt    <= '0;
              data_o <= {line, data_o[DATA_W-1:1]};
              if (idx == LAST_IDX) begin
                par_used_o <= par_en;
                state      <= par_en ? ST_PAR : ST_STOP;
              end else idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (at_full) begin
              cnt    <= '0;
              pbit_o <= line;
              state  <= ST_STOP;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (at_full) begin
              cnt    <= '0;
              stop_o <= line;
              done_o <= 1'b1;
              state  <= ST_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  input  logic              frm_evt,
  input  logic              par_evt,
  input  logic              rd,
  input  logic              clr_ovr,
  input  logic              clr_frm,
  input  logic              clr_par,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              frm_o,
  output logic              par_o,
  output logic              xfer_o,
  output logic              ovr_evt_o
);
  logic full_eff;

  assign full_eff  = full_o && !rd;
  assign xfer_o    = done && !full_eff;
  assign ovr_evt_o = done && full_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      full_o  <= 1'b0;
      ovr_o   <= 1'b0;
      frm_o   <= 1'b0;
      par_o   <= 1'b0;
    end else begin
      if (xfer_o) rdata_o <= data;
      full_o <= xfer_o || full_eff;
      ovr_o  <= ovr_evt_o || (ovr_o && !clr_ovr);
      frm_o  <= frm_evt   || (frm_o && !clr_frm);
      par_o  <= par_evt   || (par_o && !clr_par);
    end
  end
endmodule

// File: rtl/uart_rx_gate.sv
module uart_rx_gate
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rx_en_i,
  input  logic              rd_data_i,
  input  logic              clr_ovr_i,
  input  logic              clr_frm_i,
  input  logic              clr_par_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              frm_err_o,
  output logic              par_err_o,
  output logic              line_o
);
  logic              line_s;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              stop_bit;
  logic              par_bit;
  logic              par_used;
  logic              frm_evt;
  logic              par_evt;
  logic              xfer_ok;
  logic              ovr_evt;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd_i), .dout(line_s)
  );

  rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16_i), .line(line_s),
    .en(rx_en_i), .par_en(par_en_i), .done_o(frame_done),
    .data_o(frame_data), .stop_o(stop_bit), .pbit_o(par_bit),
    .par_used_o(par_used)
  );

  assign frm_evt = frame_done && !stop_bit;
  assign par_evt = frame_done && par_used &&
                   par_mismatch(8'(frame_data), par_bit, par_odd_i);

  rx_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .data(frame_data),
    .frm_evt(frm_evt), .par_evt(par_evt), .rd(rd_data_i),
    .clr_ovr(clr_ovr_i), .clr_frm(clr_frm_i), .clr_par(clr_par_i),
    .rdata_o(rdata_o), .full_o(full_o), .ovr_o(ovr_o), .frm_o(frm_err_o),
    .par_o(par_err_o), .xfer_o(xfer_ok), .ovr_evt_o(ovr_evt)
  );

  assign line_o = line_s;
endmodule

// File: rtl/uart_rx_gate_chk.sv
module uart_rx_gate_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en_i,
  input logic              clr_ovr_i,
  input logic              clr_frm_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              full_o,
  input logic              ovr_o,
  input logic              frm_err_o,
  input logic              par_err_o,
  input logic              frame_done,
  input logic [DATA_W-1:0] frame_data,
  input logic              frm_evt,
  input logic              par_evt,
  input logic              xfer_ok,
  input logic              ovr_evt
);
  AST_XFER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok |=> full_o && rdata_o == $past(frame_data)); // R3
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_o && $stable(rdata_o)); // R4
  AST_FRM_STILL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_evt && !full_o) |=> frm_err_o && rdata_o == $past(frame_data)); // R5
  AST_PAR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    par_evt |=> par_err_o); // R6
  AST_COMBO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && frm_evt) |=> ovr_o && frm_err_o && $stable(rdata_o)); // R7
  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err_o && !clr_frm_i) |=> frm_err_o); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !clr_ovr_i) |=> ovr_o); // R8
  AST_FRM_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_err_o && !frame_done) |=> !frm_err_o); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !frame_done); // R9
endmodule

bind uart_rx_gate uart_rx_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .clr_ovr_i(clr_ovr_i),
  .clr_frm_i(clr_frm_i), .rdata_o(rdata_o), .full_o(full_o), .ovr_o(ovr_o),
  .frm_err_o(frm_err_o), .par_err_o(par_err_o), .frame_done(frame_done),
  .frame_data(frame_data), .frm_evt(frm_evt), .par_evt(par_evt),
  .xfer_ok(xfer_ok), .ovr_evt(ovr_evt)
);

// File: tb/sim_uart_rx_gate.sv
`timescale 1ns/1ps
module sim_uart_rx_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0, pen = 1'b0, podd = 1'b0, ren = 1'b0;
  logic rd = 1'b0, c_ovr = 1'b0, c_frm = 1'b0, c_par = 1'b0;
  logic [7:0] rdata;
  logic full, ovr, frm, par, line;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  localparam int BIT_CLK = 64;  // 16 ticks of 4 clocks

  // {stop, flip_parity, odd, par_en, data}
  localparam logic [11:0] VEC [0:7] = '{
    12'h855, 12'h9A3, 12'hB3C, 12'hD81, 12'h07E, 12'h7F0, 12'h900, 12'hBFF
  };

  always #5 clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 3);
  end

  uart_rx_gate u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick16_i(tick), .par_en_i(pen),
    .par_odd_i(podd), .rx_en_i(ren), .rd_data_i(rd), .clr_ovr_i(c_ovr),
    .clr_frm_i(c_frm), .clr_par_i(c_par), .rdata_o(rdata), .full_o(full),
    .ovr_o(ovr), .frm_err_o(frm), .par_err_o(par), .line_o(line)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pe, input logic od,
                      input logic flip, input logic stop);
    pen = pe; podd = od;
    hold(1'b0, BIT_CLK);
    for (int i = 0; i < 8; i++) hold(d[i], BIT_CLK);
    if (pe) hold(((^d) ^ od) ^ flip, BIT_CLK);
    hold(stop, BIT_CLK);
    hold(1'b1, BIT_CLK);
  endtask

  task automatic pulse_all();
    @(negedge clk); rd = 1; c_ovr = 1; c_frm = 1; c_par = 1;
    @(negedge clk); rd = 0; c_ovr = 0; c_frm = 0; c_par = 0;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rdata == 8'h00 && !full && !ovr && !frm && !par, "R11", {rdata, full, ovr, frm, par}, 0);
    chk(line == 1'b1, "R11 line", line, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R10 line view follows rxd two clocks later
    rxd = 0; @(negedge clk);
    chk(line == 1'b1, "R10 early", line, 1);
    @(negedge clk);
    chk(line == 1'b0, "R10", line, 0);
    rxd = 1; repeat (3) @(negedge clk);

    ren = 1;
    repeat (8) @(negedge clk);

    // Vector table: R2 R3 R5 R6
    foreach (VEC[k]) begin
      automatic logic [7:0] d = VEC[k][7:0];
      automatic logic pe = VEC[k][8], od = VEC[k][9], fl = VEC[k][10], st = VEC[k][11];
      pulse_all();
      send(d, pe, od, fl, st);
      chk(rdata == d, "R2 data", rdata, d);
      chk(full == 1'b1, "R3 full", full, 1);
      chk(frm == !st, "R5 frm", frm, !st);
      chk(par == (pe & fl), "R6 par", par, pe & fl);
      chk(ovr == 1'b0, "R4 no ovr", ovr, 0);
    end

    // R3 read clears full
    @(negedge clk); rd = 1; @(negedge clk); rd = 0;
    chk(full == 1'b0, "R3 read", full, 0);

    // R1 glitch on start bit rejected
    pulse_all();
    hold(1'b0, 20);
    hold(1'b1, 12 * BIT_CLK);
    chk(full == 1'b0 && frm == 1'b0, "R1 glitch", {full, frm}, 0);
    send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(rdata == 8'h5A && full, "R1 after glitch", rdata, 8'h5A);

    // R4 overrun: full still set, new char blocked
    send(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(ovr == 1'b1, "R4 ovr", ovr, 1);
    chk(rdata == 8'h5A, "R4 data kept", rdata, 8'h5A);

    // R7 overrun + framing + parity
    @(negedge clk); c_ovr = 1; @(negedge clk); c_ovr = 0;
    send(8'h96, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(ovr && frm && par, "R7 flags", {ovr, frm, par}, 3'b111);
    chk(rdata == 8'h5A, "R7 data kept", rdata, 8'h5A);

    // R8 own clear only
    @(negedge clk); c_ovr = 1; @(negedge clk); c_ovr = 0;
    chk(!ovr && frm && par, "R8 clr ovr", {ovr, frm, par}, 3'b011);
    @(negedge clk); c_par = 1; @(negedge clk); c_par = 0;
    chk(frm && !par, "R8 clr par", {frm, par}, 2'b10);

    // R9 disable keeps flags and blocks reception
    ren = 0;
    repeat (4) @(negedge clk);
    chk(frm == 1'b1 && full == 1'b1, "R9 flags kept", {frm, full}, 2'b11);
    pulse_all();
    send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(full == 1'b0 && rdata == 8'h5A, "R9 no receive", {full, rdata}, {1'b0, 8'h5A});
    ren = 1;
    repeat (8) @(negedge clk);

    // R8 break: framing flag sets again after clear
    pulse_all();
    pen = 0;
    hold(1'b0, 11 * BIT_CLK);
    chk(frm == 1'b1, "R8 break frm", frm, 1);
    @(negedge clk); c_frm = 1; @(negedge clk); c_frm = 0;
    chk(frm == 1'b0, "R8 frm cleared", frm, 0);
    hold(1'b0, 11 * BIT_CLK);
    chk(frm == 1'b1, "R8 frm re-set", frm, 1);
    chk(rdata == 8'h00, "R5 break data", rdata, 0);
    hold(1'b1, 12 * BIT_CLK);
    pulse_all();
    chk(!ovr && !frm && !par && !full, "R8 all cleared", {ovr, frm, par, full}, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule